// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command receiver of a serial flash whose pages hold 528 bytes. It watches the chip select, serial clock and serial data pins and brings them into the system clock domain through synchronisers. It finds the serial clock edges in that domain. From the start of each select window it collects a 32-bit header: an 8-bit command code, then a 24-bit address field.

Once the header is complete, the block splits the address field. The page index and the byte offset are delivered as two separate fields, not as one linear address. The byte offset serves both as the position inside a main-memory page and as the position inside a 528-byte buffer. A header whose byte offset points past the end of a page gets an error strobe in place of the command strobe. Downstream logic (array control, buffer control) uses the registered fields when one of the two strobes pulses. Both fields hold their values until the next complete header.

Top module: `sfl_cmd_frontend`

## Requirements
- R1: While reset is held and on the first clock after it is released, both strobes are low and the command code, page and byte outputs are all zero.
- R2: In SPI mode 0 (clock idles low), the serial data line is sampled on each rising clock edge and the first 32 bits after select falls are taken most significant bit first. Bits 31..24 of that header become the command code. `cmd_valid` is high for exactly one system clock, 4 system clocks after the system clock edge on which the 32nd rising serial clock edge was driven.
- R3: SPI mode 3 (clock idles high, select falls and rises while the clock is high) gives the same header, fields and strobe timing as mode 0.
- R4: Header bits 23..22 are ignored. Bits 21..10 are the 12-bit page index on `cmd_page`, and bits 9..0 are the 10-bit byte offset on `cmd_byte`; the byte offset also serves as the buffer byte address.
- R5: A byte offset of 528 or more produces a one-clock `cmd_range_err` pulse, with the same timing as R2, and no `cmd_valid` pulse. An offset of 527 is accepted.
- R6: If select rises before 32 bits have been sampled, the partial header is dropped. Neither strobe pulses, the fields keep their values, and the next select window starts from bit zero.
- R7: Rising clock edges after the 32nd one in the same select window produce no strobe and leave the command code, page and byte outputs unchanged.
- R8: `cmd_valid` and `cmd_range_err` are never high together, and each pulse lasts one system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip select (asynchronous) |
| spi_si | input | 1 | Serial data into the device (asynchronous) |
| cmd_valid | output | 1 | One-clock strobe: a header was received with an in-range offset |
| cmd_range_err | output | 1 | One-clock strobe: a header was received with an offset of 528 or more |
| cmd_opcode | output | 8 | Command code of the last complete header |
| cmd_page | output | 12 | Page index of the last complete header |
| cmd_byte | output | 10 | Byte offset (page or buffer) of the last complete header |

## Verification
The embedded assertions check on every cycle that the two strobes never overlap and never stretch past one clock. They also check that an accepted offset is always below 528, that the decoded fields change only when a header completes, that the bit counter never passes 32, and that a high select clears the counter. Only the bench's scenarios can show that a header decodes into the right field values, MSB first, in both clock polarities. The same holds for the fixed four-clock latency, the 527/528 boundary, dropped short headers, and trailing data bits that cause no second strobe. The bench's per-clock model compares every output against an independently built frame queue.

// File: rtl/sfl_pkg.sv
// Shared widths and the decoded command type for the serial flash
// command front-end. Assumes a 528-byte page and a 32-bit header.
package sfl_pkg;
    localparam int OP_W       = 8;
    localparam int ADDR_W     = 24;
    localparam int PAGE_W     = 12;
    localparam int BYTE_W     = 10;
    localparam int PAGE_BYTES = 528;
    localparam int FRAME_W    = OP_W + ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PAGE_W-1:0] page;
        logic [BYTE_W-1:0] offs;
    } sfl_cmd_t;
endpackage

// File: rtl/sfl_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each pin is held for several system clocks between changes,
// so all bits of the bundle cross with the same latency.
module sfl_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pins through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfl_shift.sv
// Header collector: detects rising serial clock edges in the system
// domain and shifts in up to FRAME_W bits, MSB first, while select is low.
// Assumes synchronised inputs; bits past FRAME_W are ignored.
module sfl_shift
    import sfl_pkg::*;
#(
    parameter int FW = FRAME_W,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          cs_n_s,
    input  logic          si_s,
    output logic [FW-1:0] frame,
    output logic          frame_done
);
    logic          sck_q;
    logic          sck_rise;
    logic [CW-1:0] cnt;
    logic [FW-1:0] sh;

    assign sck_rise = sck_s & ~sck_q;
    assign frame    = sh;

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Count and shift header bits; a high select drops the partial header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (cs_n_s) begin
            cnt <= '0;
        end else if (sck_rise && cnt != CW'(FW)) begin
            sh  <= {sh[FW-2:0], si_s};
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the clock on which the last header bit lands.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_done <= 1'b0;
        else        frame_done <= !cs_n_s && sck_rise && (cnt == CW'(FW - 1));
    end

    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(FW));
    a_r6_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (cnt == '0));
    a_r2_done_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (cnt == CW'(FW)));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: rtl/sfl_decode.sv
// Field splitter: separates command code, page index and byte offset,
// checks the offset against the page size and registers the result
// with a one-clock strobe. Assumes frame is stable while done is high.
module sfl_decode
    import sfl_pkg::*;
#(
    parameter int PW = PAGE_W,
    parameter int BW = BYTE_W,
    parameter int OW = OP_W,
    parameter int NB = PAGE_BYTES,
    localparam int FW = OW + ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] frame,
    input  logic          frame_done,
    output logic          cmd_valid,
    output logic          cmd_range_err,
    output logic [OW-1:0] cmd_op,
    output logic [PW-1:0] cmd_page,
    output logic [BW-1:0] cmd_offs
);
    localparam logic [BW-1:0] OFFS_LIMIT = BW'(NB);

    logic [OW-1:0] op_w;
    logic [PW-1:0] page_w;
    logic [BW-1:0] offs_w;
    logic          in_range;

    // Split the header; the bits between page and code are don't-care.
    always_comb begin
        op_w     = frame[FW-1 -: OW];
        page_w   = frame[PW+BW-1 : BW];
        offs_w   = frame[BW-1:0];
        in_range = offs_w < OFFS_LIMIT;
    end

    // Register strobes and latch fields on a completed header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid     <= 1'b0;
            cmd_range_err <= 1'b0;
            cmd_op        <= '0;
            cmd_page      <= '0;
            cmd_offs      <= '0;
        end else begin
            cmd_valid     <= frame_done && in_range;
            cmd_range_err <= frame_done && !in_range;
            if (frame_done) begin
                cmd_op   <= op_w;
                cmd_page <= page_w;
                cmd_offs <= offs_w;
            end
        end
    end

    a_r5_valid_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_offs < OFFS_LIMIT));
    a_r5_err_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_range_err |-> (cmd_offs >= OFFS_LIMIT));
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, cmd_range_err}));
    a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> ($stable(cmd_op) && $stable(cmd_page) && $stable(cmd_offs)));
endmodule

// File: rtl/sfl_cmd_frontend.sv
// Serial flash command front-end top: synchronises the SPI pins into
// the system clock, collects a 32-bit header (modes 0 and 3) and hands
// the decoded command code, page index and byte offset downstream.
// Assumes the system clock is well above twice the serial clock rate.
module sfl_cmd_frontend
    import sfl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              cmd_valid,
    output logic              cmd_range_err,
    output logic [OP_W-1:0]   cmd_opcode,
    output logic [PAGE_W-1:0] cmd_page,
    output logic [BYTE_W-1:0] cmd_byte
);
    logic [2:0]         pins_s;
    logic [FRAME_W-1:0] frame;
    logic               frame_done;

    sfl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_si}),
        .q     (pins_s)
    );

    sfl_shift #(.FW(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s[2]),
        .cs_n_s     (pins_s[1]),
        .si_s       (pins_s[0]),
        .frame      (frame),
        .frame_done (frame_done)
    );

    sfl_decode #(.PW(PAGE_W), .BW(BYTE_W), .OW(OP_W), .NB(PAGE_BYTES)) u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame         (frame),
        .frame_done    (frame_done),
        .cmd_valid     (cmd_valid),
        .cmd_range_err (cmd_range_err),
        .cmd_op        (cmd_opcode),
        .cmd_page      (cmd_page),
        .cmd_offs      (cmd_byte)
    );
endmodule

// File: tb/sfl_cmd_frontend_tb.sv
// Bench: drives SPI headers in modes 0 and 3 and compares every output
// on every clock against a queue-based behavioural model.
module sfl_cmd_frontend_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int LATENCY    = 4;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_si = 1'b0;
    logic        cmd_valid, cmd_range_err;
    logic [7:0]  cmd_opcode;
    logic [11:0] cmd_page;
    logic [9:0]  cmd_byte;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    bit done = 0;

    int          due_q[$];
    logic [31:0] frm_q[$];
    logic        e_valid = 0, e_err = 0;
    logic [7:0]  e_op = 0;
    logic [11:0] e_page = 0;
    logic [9:0]  e_byte = 0;

    sfl_cmd_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .cmd_valid(cmd_valid), .cmd_range_err(cmd_range_err),
        .cmd_opcode(cmd_opcode), .cmd_page(cmd_page), .cmd_byte(cmd_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Clock counter and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    // Reference model and per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        e_valid = 0;
        e_err   = 0;
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            logic [31:0] f;
            void'(due_q.pop_front());
            f = frm_q.pop_front();
            e_op   = f[31:24];
            e_page = f[21:10];
            e_byte = f[9:0];
            e_valid = (f[9:0] < 10'd528);
            e_err   = !e_valid;
        end
        if (cmd_valid || cmd_range_err) pulses++;
        chk(cmd_valid == e_valid, "R2", "cmd_valid", cmd_valid, e_valid);
        chk(cmd_range_err == e_err, "R5", "cmd_range_err", cmd_range_err, e_err);
        chk(!(cmd_valid && cmd_range_err), "R8", "both strobes", 1, 0);
        chk(cmd_opcode == e_op, "R2", "cmd_opcode", cmd_opcode, e_op);
        chk(cmd_page == e_page, "R4", "cmd_page", cmd_page, e_page);
        chk(cmd_byte == e_byte, "R4", "cmd_byte", cmd_byte, e_byte);
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits MSB first; mode3 selects a high idle clock.
    task automatic spi_xfer(input logic [63:0] data, input int nbits, input bit mode3);
        @(negedge clk);
        spi_sck = mode3;
        wait_clk(3);
        spi_cs_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < nbits; i++) begin
            spi_sck = 1'b0;
            spi_si  = data[nbits-1-i];
            wait_clk(HALF);
            spi_sck = 1'b1;
            if (i == 31) begin
                due_q.push_back(cyc + LATENCY);
                frm_q.push_back(data[nbits-1 -: 32]);
            end
            wait_clk(HALF);
        end
        if (!mode3) spi_sck = 1'b0;
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(8);
    endtask

    function automatic logic [31:0] hdr(input logic [7:0] op, input logic [1:0] dc,
                                        input logic [11:0] pg, input logic [9:0] by);
        return {op, dc, pg, by};
    endfunction

    initial begin
        int p0;
        wait_clk(4);
        // R1: reset state
        chk(!cmd_valid && !cmd_range_err, "R1", "strobes in reset", {cmd_valid, cmd_range_err}, 0);
        chk(cmd_opcode == 0 && cmd_page == 0 && cmd_byte == 0, "R1", "fields in reset",
            {cmd_opcode, cmd_page, cmd_byte}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid && cmd_page == 0, "R1", "state after release", {cmd_valid, cmd_page}, 0);

        // R2/R4: mode 0, don't-care bits set
        p0 = pulses;
        spi_xfer({32'h0, hdr(8'hD2, 2'b11, 12'hABC, 10'h123)}, 32, 0);
        chk(pulses == p0 + 1, "R2", "mode 0 strobe count", pulses - p0, 1);

        // R3/R5: mode 3, boundary offset 527 accepted
        p0 = pulses;
        spi_xfer({32'h0, hdr(8'h53, 2'b01, 12'h001, 10'd527)}, 32, 1);
        chk(pulses == p0 + 1, "R3", "mode 3 strobe count", pulses - p0, 1);

        // R5: offsets 528 and 1023 rejected
        spi_xfer({32'h0, hdr(8'h82, 2'b00, 12'h7A5, 10'd528)}, 32, 0);
        spi_xfer({32'h0, hdr(8'h0F, 2'b10, 12'hFFF, 10'd1023)}, 32, 1);
        chk(cmd_byte == 10'd1023, "R5", "rejected offset latched", cmd_byte, 10'd1023);

        // R6: short header dropped, fields unchanged
        p0 = pulses;
        spi_xfer({44'h0, 20'hFA5A5}, 20, 0);
        chk(pulses == p0, "R6", "no strobe on short header", pulses - p0, 0);
        chk(cmd_opcode == 8'h0F, "R6", "opcode kept", cmd_opcode, 8'h0F);
        spi_xfer({32'h0, hdr(8'hE8, 2'b00, 12'hFFF, 10'd0)}, 32, 0);
        chk(cmd_page == 12'hFFF && cmd_byte == 0, "R6", "clean header after abort",
            {cmd_page, cmd_byte}, {12'hFFF, 10'd0});

        // R7: trailing data bits ignored
        p0 = pulses;
        spi_xfer({hdr(8'h84, 2'b00, 12'h3C3, 10'h0AA), 32'hFFFF_FFFF}, 64, 1);
        chk(pulses == p0 + 1, "R7", "single strobe with trailing data", pulses - p0, 1);
        chk(cmd_opcode == 8'h84 && cmd_byte == 10'h0AA, "R7", "fields hold after data",
            {cmd_opcode, cmd_byte}, {8'h84, 10'h0AA});

        wait_clk(10);
        chk(due_q.size() == 0, "R2", "all expected strobes consumed", due_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule